// File: doc/BRIEF.md
# Page-Bounded Bus-Mastering DMA Mover

This block copies a run of words from a peripheral data source into memory over a shared synchronous bus, with no processor involvement per word. Software writes a physical start address and a word count into two configuration registers, then writes a start bit. The mover checks that the whole run stays inside one memory page and that the start address is word aligned. It then requests the bus, waits for the grant, and moves one word per accepted bus transfer, stepping the address by the word size after each one. When the last word is accepted, or when the bus reports an error, it gives the bus back and raises a level interrupt.

The peripheral side is a valid/ready handshake: the mover pulls one word into a holding register and presents it on the bus together with its address. A slave can stretch any transfer by holding the wait input high. A run that would leave the page, a misaligned start, or a zero count is settled at once, without touching the bus.

Register map (select input `regSel`): 0 = start byte address, 1 = word count, 2 = control (bit 0 starts a run, bit 1 clears the interrupt), 3 = status (bit 0 busy, bit 1 done, bit 2 error). Writes to selects 0 and 1 take effect only while the mover is idle.

Top module: `dma_page_mover`

## Requirements
- R1: While reset is held, `busReq`, `busValid`, `busRelease` and `irq` are low and the status register reads 0.
- R2: After a start, `busReq` rises in the next cycle and stays high, and `busValid` is never high unless `busGrant` is high.
- R3: The k-th accepted transfer (counting from 0; a transfer is accepted in a cycle where `busValid` is high and `busWait` and `busErr` are low) carries address start + k × (DATA_W/8) and the k-th word taken from the source (a word is taken in a cycle where `srcValid` and `srcReady` are both high).
- R4: In the cycle after the last word is accepted, `busReq` is low and `busRelease` is high for exactly one cycle, `irq` is high, and status reads busy=1, done=1, error=0; one cycle later status reads done only.
- R5: A start whose byte offset within the page plus count × (DATA_W/8) exceeds the page size 2^PAGE_W, or whose address is not a multiple of DATA_W/8, sets the error bit (status 3'b100) and `irq` at once, and `busReq` never rises; the rejection takes precedence over a zero count.
- R6: While a presented word is held off by `busWait` (and `busErr` is low), `busValid`, `busAddr` and `busData` stay unchanged into the next cycle.
- R7: `busErr` high while a word is presented aborts the run: no further transfer is accepted, the next cycle shows `busReq` low with `busRelease` high, and status reads busy=1, done=0, error=1 with `irq` high.
- R8: A start with a word count of 0 (and a valid address) sets the done bit (status 3'b010) and `irq` at once, without requesting the bus.
- R9: `irq`, once set, stays high until a control write with bit 1 set, after which it reads low.
- R10: Writes to the start address and word count registers, and start writes, made while a run is in progress have no effect; the address register reads back the value written before the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for write and read |
| regWrData | input | REG_W | Register write value |
| regRdData | output | REG_W | Register read value for `regSel` |
| busReq | output | 1 | Bus request, high while the mover wants or holds the bus |
| busGrant | input | 1 | Bus grant from the arbiter |
| busRelease | output | 1 | One-cycle pulse when the bus is handed back |
| busValid | output | 1 | Address and data on the bus are a transfer |
| busAddr | output | ADDR_W | Byte address of the current word |
| busData | output | DATA_W | Current data word |
| busWait | input | 1 | Slave stretches the current transfer |
| busErr | input | 1 | Slave or bus error, aborts the run |
| srcValid | input | 1 | Peripheral offers a word |
| srcData | input | DATA_W | Peripheral word |
| srcReady | output | 1 | Mover takes the offered word this cycle |
| irq | output | 1 | Completion or error interrupt, level |

## Verification
The bench builds the mover with an 8-bit address, 16-bit words, a 32-byte page of sixteen words and a 6-bit count, so a page is small enough to sweep every word offset in it against every count from 0 to one past the page length. That sweep puts runs that end exactly on the page edge, runs that overrun it by one word, zero counts and one-word runs all within reach, while grant delay, source stalls and slave waits vary with the case. A subset of runs aborts halfway through with a bus error, a few start at a misaligned address, and a few receive configuration writes mid-run.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

  // Register selects
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  // Control register bits
  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } moverState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // copy configuration into the working counters
    logic take;     // capture a source word into the holding register
    logic advance;  // a word was accepted: step address, count down
  } dpStrobe_t;

endpackage

// File: rtl/dma_mover_datapath.sv
module dma_mover_datapath
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrBase,
  input  logic              wrCount,
  input  logic [ADDR_W-1:0] wrAddrVal,
  input  logic [CNT_W-1:0]  wrCountVal,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] srcData,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [CNT_W-1:0]  cfgCount,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              haveWord,
  output logic              lastWord,
  output logic              countZero,
  output logic              rangeBad
);

  localparam int BYTES     = DATA_W / 8;
  localparam int STEP_LOG2 = $clog2(BYTES);
  localparam int SPAN_W    = CNT_W + STEP_LOG2;
  localparam int SUM_W     = ((PAGE_W > SPAN_W) ? PAGE_W : SPAN_W) + 1;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;
  logic [DATA_W-1:0] holdData;
  logic [SUM_W-1:0]  endOff;
  logic [SUM_W-1:0]  pageSize;
  logic              overrun;
  logic              misaligned;

  // Software-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddr  <= '0;
      cfgCount <= '0;
    end else begin
      if (wrBase)  cfgAddr  <= wrAddrVal;
      if (wrCount) cfgCount <= wrCountVal;
    end
  end

  // Working address, remaining count and holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remain   <= '0;
      holdData <= '0;
      haveWord <= 1'b0;
    end else begin
      if (strb.load) begin
        curAddr  <= cfgAddr;
        remain   <= cfgCount;
        haveWord <= 1'b0;
      end else if (strb.advance) begin
        curAddr  <= curAddr + ADDR_W'(BYTES);
        remain   <= remain - CNT_W'(1);
        haveWord <= 1'b0;
      end else if (strb.take) begin
        holdData <= srcData;
        haveWord <= 1'b1;
      end
    end
  end

  // Page bound: offset inside the page plus byte span must fit
  assign endOff   = SUM_W'(cfgAddr[PAGE_W-1:0]) + (SUM_W'(cfgCount) << STEP_LOG2);
  assign pageSize = SUM_W'(1) << PAGE_W;
  assign overrun  = endOff > pageSize;

  generate
    if (STEP_LOG2 > 0) begin : g_align
      assign misaligned = |cfgAddr[STEP_LOG2-1:0];
    end else begin : g_noAlign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign rangeBad  = overrun | misaligned;
  assign countZero = (cfgCount == '0);
  assign lastWord  = (remain == CNT_W'(1));
  assign busAddr   = curAddr;
  assign busData   = holdData;

endmodule

// File: rtl/dma_mover_ctrl.sv
module dma_mover_ctrl
  import dma_mover_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      goPulse,
  input  logic      clrIrq,
  input  logic      busGrant,
  input  logic      busWait,
  input  logic      busErr,
  input  logic      srcValid,
  input  logic      rangeBad,
  input  logic      countZero,
  input  logic      lastWord,
  input  logic      haveWord,
  output dpStrobe_t strb,
  output logic      busReq,
  output logic      busValid,
  output logic      busRelease,
  output logic      srcReady,
  output logic      busy,
  output logic      doneFlag,
  output logic      errFlag,
  output logic      irq
);

  moverState_t st, stNext;
  logic doneSet, errSet, flagClr;

  always_comb begin
    stNext  = st;
    strb    = '0;
    doneSet = 1'b0;
    errSet  = 1'b0;
    flagClr = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (goPulse) begin
          flagClr = 1'b1;
          if (rangeBad) begin
            errSet = 1'b1;
          end else if (countZero) begin
            doneSet = 1'b1;
          end else begin
            strb.load = 1'b1;
            stNext    = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (busGrant) stNext = ST_XFER;
      end
      ST_XFER: begin
        if (busErr) begin
          errSet = 1'b1;
          stNext = ST_FIN;
        end else begin
          if (!haveWord && srcValid) strb.take = 1'b1;
          if (haveWord && !busWait) begin
            strb.advance = 1'b1;
            if (lastWord) begin
              doneSet = 1'b1;
              stNext  = ST_FIN;
            end
          end
        end
      end
      ST_FIN: stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st <= stNext;
      if (flagClr) begin
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
      end
      if (doneSet) doneFlag <= 1'b1;
      if (errSet)  errFlag  <= 1'b1;
      if (doneSet || errSet) irq <= 1'b1;
      else if (clrIrq)       irq <= 1'b0;
    end
  end

  assign busReq     = (st == ST_REQ) || (st == ST_XFER);
  assign busValid   = (st == ST_XFER) && haveWord;
  assign srcReady   = (st == ST_XFER) && !haveWord && !busErr;
  assign busRelease = (st == ST_FIN);
  assign busy       = (st != ST_IDLE);

endmodule

// File: rtl/dma_page_mover.sv
module dma_page_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busRelease,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  input  logic              busWait,
  input  logic              busErr,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  output logic              irq
);

  dpStrobe_t         strb;
  logic              busy, doneFlag, errFlag;
  logic              haveWord, lastWord, countZero, rangeBad;
  logic              wrCtrl, goPulse, clrIrq, wrBase, wrCount;
  logic [ADDR_W-1:0] cfgAddr;
  logic [CNT_W-1:0]  cfgCount;
  logic              unusedWrBits;

  assign wrCtrl  = regWrEn && (regSel == SEL_CTRL);
  assign goPulse = wrCtrl && regWrData[CTRL_GO_BIT];
  assign clrIrq  = wrCtrl && regWrData[CTRL_CLR_BIT];
  assign wrBase  = regWrEn && (regSel == SEL_BASE)  && !busy;
  assign wrCount = regWrEn && (regSel == SEL_COUNT) && !busy;
  assign unusedWrBits = ^regWrData;

  always_comb begin
    unique case (regSel)
      SEL_BASE:  regRdData = REG_W'(cfgAddr);
      SEL_COUNT: regRdData = REG_W'(cfgCount);
      SEL_STAT:  regRdData = REG_W'({errFlag, doneFlag, busy});
      default:   regRdData = '0;
    endcase
  end

  dma_mover_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .goPulse(goPulse), .clrIrq(clrIrq),
    .busGrant(busGrant), .busWait(busWait), .busErr(busErr),
    .srcValid(srcValid),
    .rangeBad(rangeBad), .countZero(countZero),
    .lastWord(lastWord), .haveWord(haveWord),
    .strb(strb),
    .busReq(busReq), .busValid(busValid), .busRelease(busRelease),
    .srcReady(srcReady), .busy(busy),
    .doneFlag(doneFlag), .errFlag(errFlag), .irq(irq)
  );

  dma_mover_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrBase(wrBase), .wrCount(wrCount),
    .wrAddrVal(regWrData[ADDR_W-1:0]), .wrCountVal(regWrData[CNT_W-1:0]),
    .strb(strb), .srcData(srcData),
    .cfgAddr(cfgAddr), .cfgCount(cfgCount),
    .busAddr(busAddr), .busData(busData),
    .haveWord(haveWord), .lastWord(lastWord),
    .countZero(countZero), .rangeBad(rangeBad)
  );

endmodule

// File: rtl/dma_mover_checker.sv
module dma_mover_checker
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 12,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic [REG_W-1:0]  regWrData,
  input logic              busReq,
  input logic              busGrant,
  input logic              busRelease,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              busWait,
  input logic              busErr,
  input logic              irq
);

  localparam int STEP = DATA_W / 8;

  logic              haveLast;
  logic [ADDR_W-1:0] lastAddr;
  logic              clrWrite;
  logic              unusedChkBits;

  assign clrWrite      = regWrEn && (regSel == SEL_CTRL) && regWrData[CTRL_CLR_BIT];
  assign unusedChkBits = ^regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastAddr <= '0;
    end else if (!busReq) begin
      haveLast <= 1'b0;
    end else if (busValid && !busWait && !busErr) begin
      haveLast <= 1'b1;
      lastAddr <= busAddr;
    end
  end

  AST_DRIVE_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busReq && busGrant); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busValid && haveLast |-> busAddr == lastAddr + ADDR_W'(STEP)); // R3

  AST_RELEASE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |-> !busReq && !busValid); // R4

  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |=> !busRelease); // R4

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    busValid && haveLast |-> busAddr[ADDR_W-1:PAGE_W] == lastAddr[ADDR_W-1:PAGE_W]); // R5

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWait && !busErr |=> busValid && $stable(busAddr) && $stable(busData)); // R6

  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busErr |=> !busReq && busRelease); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irq && !clrWrite |=> irq); // R9

endmodule

bind dma_page_mover dma_mover_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .REG_W(REG_W)
) u_chk (.*);

// File: tb/sim_dma_page_mover.sv
module sim_dma_page_mover;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int PAGE_W = 5;
  localparam int CNT_W  = 6;
  localparam int REG_W  = 16;
  localparam int STEP   = DATA_W / 8;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_WORDS = PAGE_BYTES / STEP;

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWrEn;
  logic [1:0]        regSel;
  logic [REG_W-1:0]  regWrData;
  logic [REG_W-1:0]  regRdData;
  logic              busReq, busGrant, busRelease, busValid;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;
  logic              busWait, busErr, srcValid, srcReady, irq;
  logic [DATA_W-1:0] srcData;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  dma_page_mover #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .busReq(busReq), .busGrant(busGrant), .busRelease(busRelease),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busWait(busWait), .busErr(busErr),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input int val);
    @(negedge clk);
    regWrEn = 1'b1;
    regSel = sel;
    regWrData = REG_W'(val);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic int readStat();
    return int'(regRdData[2:0]);
  endfunction

  // Start rejected or settled at once (R5 for a bad range, R8 for count 0)
  task automatic runNoBus(input int addr, input int cnt, input bit expBad);
    int reqSeen = 0;
    string tag;
    tag = expBad ? "R5" : "R8";
    wrReg(2'd0, addr);
    wrReg(2'd1, cnt);
    wrReg(2'd2, 1);
    regSel = 2'd3;
    #1;
    chk(irq == 1'b1, tag, "irq after immediate finish", int'(irq), 1);
    chk(readStat() == (expBad ? 4 : 2), tag, "status after immediate finish",
        readStat(), expBad ? 4 : 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      if (busReq) reqSeen++;
    end
    chk(reqSeen == 0, tag, "bus request cycles", reqSeen, 0);
    chk(irq == 1'b1, "R9", "irq held without clear", int'(irq), 1);
    wrReg(2'd2, 2);
    #1;
    chk(irq == 1'b0, "R9", "irq after clear write", int'(irq), 0);
  endtask

  task automatic runXfer(input int offW, input int cnt, input int errAt,
                         input bit poke, input int caseId);
    int startAddr;
    int seed;
    int popped = 0;
    int k = 0;
    int reqAge = 0;
    int expWords;
    bit released = 0;
    bit holdPend = 0;
    int holdAddr = 0;
    int holdData = 0;
    int badDrive = 0;
    bit waitNow, errNow;
    startAddr = 'h40 + offW * STEP;
    seed = (caseId * 37 + 5) & 16'hFFFF;
    expWords = (errAt >= 0) ? errAt : cnt;
    wrReg(2'd0, startAddr);
    wrReg(2'd1, cnt);
    srcData = DATA_W'(seed);
    wrReg(2'd2, 1);
    for (int cyc = 0; cyc < 400 && !released; cyc++) begin
      if (cyc > 0) @(negedge clk);
      #1;
      if (cyc == 0) begin
        chk(busReq == 1'b1, "R2", "request after start", int'(busReq), 1);
        chk(busValid == 1'b0, "R2", "no drive before grant", int'(busValid), 0);
      end
      if (busRelease) begin
        released = 1;
      end else begin
        if (holdPend) begin
          chk(busValid == 1'b1 && int'(busAddr) == holdAddr && int'(busData) == holdData,
              "R6", "word held under wait (addr)", int'(busAddr), holdAddr);
          holdPend = 0;
        end
        if (busValid && !busGrant) badDrive++;
        busGrant = busReq && (reqAge >= (cnt % 3));
        if (busReq) reqAge++;
        errNow  = busValid && (k == errAt);
        waitNow = busValid && !errNow && (((cyc + cnt) % 3) == 0);
        busErr  = errNow;
        busWait = waitNow;
        srcValid = (((cyc + offW) % 4) != 1);
        srcData  = DATA_W'(seed + popped);
        regWrEn = 1'b0;
        if (poke && cyc == 4) begin
          regWrEn = 1'b1; regSel = 2'd0; regWrData = REG_W'('h80);
        end else if (poke && cyc == 5) begin
          regWrEn = 1'b1; regSel = 2'd1; regWrData = REG_W'(3);
        end else if (poke && cyc == 6) begin
          regWrEn = 1'b1; regSel = 2'd2; regWrData = REG_W'(1);
        end
        #1;
        if (srcValid && srcReady) popped++;
        if (busValid && !waitNow && !errNow) begin
          chk(int'(busAddr) == startAddr + k * STEP, "R3", "word address",
              int'(busAddr), startAddr + k * STEP);
          chk(int'(busData) == ((seed + k) & 16'hFFFF), "R3", "word data",
              int'(busData), (seed + k) & 16'hFFFF);
          k++;
        end
        if (busValid && waitNow) begin
          holdPend = 1;
          holdAddr = int'(busAddr);
          holdData = int'(busData);
        end
      end
    end
    regWrEn = 1'b0; busErr = 1'b0; busWait = 1'b0; srcValid = 1'b0;
    regSel = 2'd3;
    #1;
    chk(released, (errAt >= 0) ? "R7" : "R4", "bus released", int'(released), 1);
    chk(k == expWords, (errAt >= 0) ? "R7" : "R3", "accepted words", k, expWords);
    chk(badDrive == 0, "R2", "drive without grant", badDrive, 0);
    chk(busReq == 1'b0, (errAt >= 0) ? "R7" : "R4", "request on release", int'(busReq), 0);
    chk(irq == 1'b1, (errAt >= 0) ? "R7" : "R4", "irq on release", int'(irq), 1);
    chk(readStat() == ((errAt >= 0) ? 5 : 3), (errAt >= 0) ? "R7" : "R4",
        "status on release", readStat(), (errAt >= 0) ? 5 : 3);
    busGrant = 1'b0;
    @(negedge clk);
    #1;
    chk(busRelease == 1'b0 && busReq == 1'b0, "R4", "release is one cycle",
        int'(busRelease), 0);
    chk(readStat() == ((errAt >= 0) ? 4 : 2), (errAt >= 0) ? "R7" : "R4",
        "status after release", readStat(), (errAt >= 0) ? 4 : 2);
    if (poke) begin
      regSel = 2'd0;
      #1;
      chk(int'(regRdData) == startAddr, "R10", "address reg after busy writes",
          int'(regRdData), startAddr);
      regSel = 2'd1;
      #1;
      chk(int'(regRdData) == cnt, "R10", "count reg after busy writes",
          int'(regRdData), cnt);
    end
    wrReg(2'd2, 2);
    #1;
    chk(irq == 1'b0, "R9", "irq after clear write", int'(irq), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int caseId = 0;
    rstN = 1'b0;
    regWrEn = 1'b0; regSel = 2'd3; regWrData = '0;
    busGrant = 1'b0; busWait = 1'b0; busErr = 1'b0;
    srcValid = 1'b0; srcData = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busReq == 1'b0 && busValid == 1'b0 && busRelease == 1'b0, "R1",
        "bus outputs in reset", int'({busReq, busValid, busRelease}), 0);
    chk(irq == 1'b0, "R1", "irq in reset", int'(irq), 0);
    chk(readStat() == 0, "R1", "status in reset", readStat(), 0);
    rstN = 1'b1;

    // Misaligned starts are rejected (R5), also with a zero count
    runNoBus('h41, 2, 1'b1);
    runNoBus('h47, 0, 1'b1);
    runNoBus('h5F, 1, 1'b1);

    // Sweep every word offset in the page against counts 0..PAGE_WORDS+1
    for (int offW = 0; offW < PAGE_WORDS; offW++) begin
      for (int cnt = 0; cnt <= PAGE_WORDS + 1; cnt++) begin
        caseId++;
        if ((offW + cnt) * STEP > PAGE_BYTES) begin
          runNoBus('h40 + offW * STEP, cnt, 1'b1);
        end else if (cnt == 0) begin
          runNoBus('h40 + offW * STEP, 0, 1'b0);
        end else begin
          runXfer(offW, cnt,
                  (cnt >= 2 && ((offW + cnt) % 5) == 2) ? cnt / 2 : -1,
                  (caseId % 11) == 5, caseId);
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule